// File: doc/BRIEF.md
# Two-Wire Temperature Register Slave

This block is the serial side of a temperature monitor. It watches a two-wire bus, where SCL is the clock and SDA is the data line, and samples both lines with the system clock. It answers a fixed 7-bit address. The high nibble of that address is 1001. The low three bits come from strap pins.

Through the bus, a host can do four things:
- read the measured temperature;
- write and read back the alarm setpoint and the hysteresis threshold;
- write and read back a small configuration byte;
- select the register for the next access by writing a pointer byte.

The block drives SDA only by pulling it low (open-drain style). Each time it loads a register byte for transmission, it sends a one-cycle strobe to the alarm logic.

The transaction engine is one state machine with these states:
- `ST_IDLE`: ignores the bus.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: pulls SDA low on a matching address.
- `ST_PTR`: receives the pointer byte.
- `ST_PTR_ACK`: acknowledges a valid pointer.
- `ST_WR`: receives one data byte.
- `ST_WR_ACK`: acknowledges an accepted data byte.
- `ST_RD`: shifts a data byte out, MSB first.
- `ST_RD_ACK`: samples the host's acknowledge.

Its transitions are:
- A START from any state goes to `ST_ADDR`. A STOP from any state goes to `ST_IDLE`.
- From `ST_ADDR`, the eighth bit goes to `ST_ADDR_ACK` on a match, or to `ST_IDLE` otherwise.
- From `ST_ADDR_ACK`, the direction bit selects `ST_RD` (read) or `ST_PTR` (write).
- From `ST_PTR`, a valid pointer goes to `ST_PTR_ACK`. An invalid one goes to `ST_IDLE`.
- `ST_PTR_ACK` goes to `ST_WR`.
- From `ST_WR`, an accepted byte goes to `ST_WR_ACK`. A refused byte goes to `ST_IDLE`.
- `ST_WR_ACK` goes back to `ST_WR`.
- `ST_RD` goes to `ST_RD_ACK`.
- From `ST_RD_ACK`, a host acknowledge goes back to `ST_RD`. A host NACK goes to `ST_IDLE`.

All moves between byte and acknowledge states happen on a falling SCL edge.

Top module: `tws_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state. A rising SDA while SCL is high (STOP) returns the block to idle from any state. Either one abandons any partly received write, which leaves the registers unchanged.
- R2: The address byte is {1001, A2, A1, A0, R/W} with R/W=1 for read. The block pulls SDA low during the ninth clock only when A2..A0 equal `strap_addr` and the high nibble is 1001. Otherwise it leaves SDA released until the next START.
- R3: Bytes are MSB first. Incoming bits are sampled on the rising SCL edge. Outgoing bits change only after a falling SCL edge.
- R4: The first byte written after the address is a pointer. Bits 1:0 select the register: 00 temperature, 01 configuration, 10 hysteresis, 11 setpoint. A pointer with any of bits 7:2 set is not acknowledged and leaves the pointer unchanged.
- R5: A 16-bit register holding a 9-bit value v is sent as v[8:1] and then {v[0], 7'b0}. While the host keeps acknowledging, these two bytes repeat alternately.
- R6: The configuration register is one byte. Writes keep bits 4:0, and bits 7:5 always read as zero.
- R7: A hysteresis or setpoint write changes the register only after both bytes, to {first byte, bit 7 of the second byte}. A write stopped after one byte changes nothing. A third data byte is not acknowledged.
- R8: The temperature register is read-only. A data byte written to it is not acknowledged and has no effect.
- R9: A read with no pointer phase returns the register named by the last valid pointer. A pointer write followed by a repeated START and a read returns the new register.
- R10: When the host does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START.
- R11: `rd_strobe` is a single-cycle pulse for every data byte loaded for transmission.
- R12: After reset: pointer 00, configuration 0, hysteresis 150 (75 °C), setpoint 160 (80 °C), SDA released.
- R13: Setting configuration bit 0 (shutdown) leaves the bus interface fully working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_addr | input | 3 | Low three address bits |
| temp_i | input | 9 | Measured temperature, two's complement half degrees |
| cfg_o | output | 5 | Stored configuration bits 4:0 |
| thyst_o | output | 9 | Hysteresis threshold |
| tset_o | output | 9 | Alarm setpoint |
| rd_strobe | output | 1 | One pulse per register byte sent |

## Verification
The assertions check, on every cycle, the following:
- START and STOP force the state machine to the address or idle state.
- An address acknowledge follows only a matching address byte, and a pointer acknowledge only a pointer with bits 7:2 clear.
- The strobe is a lone pulse at entry to the read state.
- Threshold registers change only on the second byte of a write, and a write enable never names the temperature register.

Only the bench scenarios can show the rest:
- the exact byte contents and their MSB-first order on the wire;
- the alternating byte pattern during long reads;
- pointer persistence across transactions;
- silence after a host NACK;
- the effect of aborted and partial writes, observed by reading registers back over the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tws_state_e;

    typedef enum logic [1:0] {
        SEL_TEMP = 2'b00,
        SEL_CFG  = 2'b01,
        SEL_HYST = 2'b10,
        SEL_SET  = 2'b11
    } tws_sel_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], d};
    end

    assign q    = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter int          DW       = 9,
    parameter int          CW       = 5,
    parameter logic [DW-1:0] HYST_RST = 9'd150,
    parameter logic [DW-1:0] SET_RST  = 9'd160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic [1:0]    ptr_wdata,
    input  logic          wr_en,
    input  logic [1:0]    wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          rd_idx,
    input  logic [DW-1:0] temp_i,
    output logic [7:0]    rd_byte,
    output logic          wr_ok,
    output logic [CW-1:0] cfg_o,
    output logic [DW-1:0] thyst_o,
    output logic [DW-1:0] tset_o
);
    localparam int PAD = 16 - DW;

    tws_sel_e      ptr;
    logic [7:0]    stage;
    logic [15:0]   wide_w;
    logic [15:0]   wide_r;
    logic [DW-1:0] val;

    assign wide_w = {stage, wr_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= SEL_TEMP;
            stage   <= '0;
            cfg_o   <= '0;
            thyst_o <= HYST_RST;
            tset_o  <= SET_RST;
        end else begin
            if (ptr_we) ptr <= tws_sel_e'(ptr_wdata);
            if (wr_en) begin
                unique case (ptr)
                    SEL_CFG:  cfg_o <= wr_data[CW-1:0];
                    SEL_HYST: if (wr_idx == 2'd0) stage <= wr_data;
                              else thyst_o <= wide_w[15 -: DW];
                    SEL_SET:  if (wr_idx == 2'd0) stage <= wr_data;
                              else tset_o <= wide_w[15 -: DW];
                    SEL_TEMP: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (ptr)
            SEL_TEMP: begin val = temp_i;  wr_ok = 1'b0;            end
            SEL_CFG:  begin val = '0;      wr_ok = (wr_idx == 2'd0); end
            SEL_HYST: begin val = thyst_o; wr_ok = (wr_idx < 2'd2);  end
            SEL_SET:  begin val = tset_o;  wr_ok = (wr_idx < 2'd2);  end
        endcase
        wide_r = {val, {PAD{1'b0}}};
        if (ptr == SEL_CFG) rd_byte = {{(8-CW){1'b0}}, cfg_o};
        else                rd_byte = rd_idx ? wide_r[7:0] : wide_r[15:8];
    end

    // R7: thresholds move only on the second byte of a write
    assert_hyst_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thyst_o) |-> ($past(wr_en) && $past(wr_idx) == 2'd1));
    assert_set_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tset_o) |-> ($past(wr_en) && $past(wr_idx) == 2'd1));
    // R8: the engine never issues a write against the temperature register
    assert_temp_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr != SEL_TEMP);
endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int            DW          = 9,
    parameter int            CW          = 5,
    parameter int            SYNC_STAGES = 2,
    parameter logic [3:0]    ADDR_HI     = 4'b1001,
    parameter logic [DW-1:0] HYST_RST    = 9'd150,
    parameter logic [DW-1:0] SET_RST     = 9'd160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    strap_addr,
    input  logic [DW-1:0] temp_i,
    output logic [CW-1:0] cfg_o,
    output logic [DW-1:0] thyst_o,
    output logic [DW-1:0] tset_o,
    output logic          rd_strobe
);
    localparam logic [3:0] BITS = 4'd8;

    tws_state_e  state, st_n;
    logic        scl_q, scl_r, scl_f;
    logic        sda_q, sda_r, sda_f;
    logic        start_det, stop_det;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic [1:0]  byte_idx;
    logic        mack;
    logic        byte_done;
    logic        addr_match, ptr_ok;
    logic        ptr_we, wr_en, load, rd_idx, wr_ok;
    logic [7:0]  rd_byte;

    tws_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_q), .rise(scl_r), .fall(scl_f));
    tws_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_q), .rise(sda_r), .fall(sda_f));

    assign start_det  = scl_q & sda_f;
    assign stop_det   = scl_q & sda_r;
    assign byte_done  = scl_f && (bitcnt == BITS);
    assign addr_match = (shreg[7:1] == {ADDR_HI, strap_addr});
    assign ptr_ok     = (shreg[7:2] == 6'd0);

    // next-state logic
    always_comb begin
        st_n = state;
        if (start_det)     st_n = ST_ADDR;
        else if (stop_det) st_n = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     st_n = ST_IDLE;
                ST_ADDR:     if (byte_done) st_n = addr_match ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_f) st_n = shreg[0] ? ST_RD : ST_PTR;
                ST_PTR:      if (byte_done) st_n = ptr_ok ? ST_PTR_ACK : ST_IDLE;
                ST_PTR_ACK:  if (scl_f) st_n = ST_WR;
                ST_WR:       if (byte_done) st_n = wr_ok ? ST_WR_ACK : ST_IDLE;
                ST_WR_ACK:   if (scl_f) st_n = ST_WR;
                ST_RD:       if (byte_done) st_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_f) st_n = mack ? ST_RD : ST_IDLE;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    assign ptr_we = (state == ST_PTR) && (st_n == ST_PTR_ACK);
    assign wr_en  = (state == ST_WR)  && (st_n == ST_WR_ACK);
    assign load   = (st_n == ST_RD) && (state == ST_ADDR_ACK || state == ST_RD_ACK);
    assign rd_idx = (state == ST_RD_ACK) ? ~byte_idx[0] : 1'b0;

    // shift, count and strobe datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            byte_idx  <= '0;
            mack      <= 1'b0;
            rd_strobe <= 1'b0;
        end else begin
            rd_strobe <= 1'b0;
            if (start_det || st_n != state) bitcnt <= '0;
            else if (scl_r && (state == ST_ADDR || state == ST_PTR ||
                               state == ST_WR   || state == ST_RD))
                bitcnt <= bitcnt + 4'd1;

            if (scl_r && (state == ST_ADDR || state == ST_PTR || state == ST_WR))
                shreg <= {shreg[6:0], sda_q};
            else if (load) begin
                shreg     <= rd_byte;
                rd_strobe <= 1'b1;
                byte_idx  <= {1'b0, rd_idx};
            end else if (state == ST_RD && scl_f && bitcnt != BITS)
                shreg <= {shreg[6:0], 1'b1};

            if (state == ST_RD_ACK && scl_r) mack <= ~sda_q;

            if (start_det || (state == ST_PTR_ACK && st_n == ST_WR))
                byte_idx <= 2'd0;
            else if (state == ST_WR_ACK && st_n == ST_WR && byte_idx != 2'd2)
                byte_idx <= byte_idx + 2'd1;
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                              sda_oe = ~shreg[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    tws_regfile #(.DW(DW), .CW(CW), .HYST_RST(HYST_RST), .SET_RST(SET_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(ptr_we), .ptr_wdata(shreg[1:0]),
        .wr_en(wr_en), .wr_idx(byte_idx), .wr_data(shreg),
        .rd_idx(rd_idx), .temp_i(temp_i),
        .rd_byte(rd_byte), .wr_ok(wr_ok),
        .cfg_o(cfg_o), .thyst_o(thyst_o), .tset_o(tset_o));

    // R1: START and STOP override every state
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR);
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> state == ST_IDLE);
    // R2: address acknowledge only after a matching address byte
    assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |->
        $past(shreg[7:1]) == {ADDR_HI, $past(strap_addr)});
    // R4: pointer acknowledge only with bits 7:2 clear
    assert_ptr_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_ACK && $past(state) == ST_PTR) |-> $past(shreg[7:2]) == 6'd0);
    // R11: strobe is a lone pulse at entry to the read state
    assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);
    assert_strobe_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> state == ST_RD);
endmodule

// File: tb/tws_slave_tb.sv
module tws_slave_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [8:0] temp  = 9'd0;
    logic       sda_oe, rd_strobe;
    logic [4:0] cfg_o;
    logic [8:0] thyst_o, tset_o;
    wire        sda_line = sda_m & ~sda_oe;

    tws_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_addr(strap), .temp_i(temp), .cfg_o(cfg_o), .thyst_o(thyst_o),
        .tset_o(tset_o), .rd_strobe(rd_strobe));

    int total = 0, fails = 0, strobes = 0, got_strobes = 0;
    logic [7:0] rb [4];
    logic [7:0] wb [3];
    logic       ak [5];
    logic       rack;

    always @(posedge clk) if (rd_strobe === 1'b1) strobes <= strobes + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq; repeat (Q) @(negedge clk); endtask
    task automatic bus_start; sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq; endtask
    task automatic bus_stop;  sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; wq; endtask
    task automatic put_bit(input logic b); sda_m = b; wq; scl_m = 1; wq; wq; scl_m = 0; wq; endtask
    task automatic get_bit(output logic b);
        sda_m = 1; wq; scl_m = 1; wq; b = sda_line; wq; scl_m = 0; wq;
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask
    task automatic get_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~mack);
    endtask

    function automatic logic [7:0] aw(input logic rw); return {4'b1001, strap, rw}; endfunction
    function automatic int hi(input logic [8:0] v); return int'(v[8:1]); endfunction
    function automatic int lo(input logic [8:0] v); return int'({v[0], 7'b0}); endfunction

    task automatic write_txn(input logic [7:0] p, input int n);
        bus_start;
        put_byte(aw(1'b0), ak[0]);
        put_byte(p, ak[1]);
        for (int i = 0; i < n; i++) put_byte(wb[i], ak[i+2]);
        bus_stop;
    endtask

    task automatic read_txn(input int n, input logic setptr, input logic [7:0] p);
        int s0;
        s0 = strobes;
        bus_start;
        if (setptr) begin
            put_byte(aw(1'b0), ak[0]);
            put_byte(p, ak[1]);
            bus_start;
        end
        put_byte(aw(1'b1), rack);
        for (int i = 0; i < n; i++) get_byte(i < n - 1, rb[i]);
        bus_stop;
        got_strobes = strobes - s0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary;
    end

    initial begin
        logic a;
        logic [8:0] tv [6];
        logic [8:0] hv [5];
        tv = '{9'h000, 9'h0FA, 9'h1FF, 9'h192, 9'h100, 9'h001};
        hv = '{9'h000, 9'h1FF, 9'h0AA, 9'h155, 9'h096};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq;
        // R12 reset state
        check("R12 sda released", sda_line, 1);
        check("R12 cfg", cfg_o, 0);
        check("R12 hyst", thyst_o, 150);
        check("R12 set", tset_o, 160);

        // R2 address sweep against strap 101
        for (int k = 0; k < 8; k++) begin
            bus_start; put_byte({4'b1001, 3'(k), 1'b0}, a); bus_stop;
            check("R2 address match", a, (k == 5) ? 1 : 0);
        end
        bus_start; put_byte({4'b1000, 3'b101, 1'b0}, a); bus_stop;
        check("R2 wrong high nibble", a, 0);
        strap = 3'b010;
        bus_start; put_byte({4'b1001, 3'b010, 1'b1}, a); get_byte(1'b0, rb[0]); bus_stop;
        check("R2 new strap", a, 1);

        // R3 R5 R9 R11 temperature reads with reset pointer, no pointer phase
        for (int k = 0; k < 6; k++) begin
            temp = tv[k];
            read_txn(2, 1'b0, 8'h00);
            check("R9 preset read ack", rack, 1);
            check("R3 R5 temp msb", rb[0], hi(tv[k]));
            check("R5 temp lsb", rb[1], lo(tv[k]));
            check("R11 strobes", got_strobes, 2);
        end

        // R7 R9 hysteresis write sweep, read back with pointer + repeated START
        for (int k = 0; k < 5; k++) begin
            wb[0] = hv[k][8:1];
            wb[1] = {hv[k][0], 7'h3F};
            write_txn(8'h02, 2);
            check("R7 acks", {ak[0], ak[1], ak[2], ak[3]}, 4'hF);
            check("R7 hyst value", thyst_o, hv[k]);
            read_txn(2, 1'b1, 8'h02);
            check("R9 hyst msb", rb[0], hi(hv[k]));
            check("R9 hyst lsb", rb[1], lo(hv[k]));
        end

        // R7 R9 setpoint write then preset-pointer read
        wb[0] = 8'h61; wb[1] = 8'h80;
        write_txn(8'h03, 2);
        check("R7 set value", tset_o, 9'h0C3);
        read_txn(2, 1'b0, 8'h00);
        check("R9 set msb preset", rb[0], 8'h61);
        check("R9 set lsb preset", rb[1], 8'h80);

        // R6 configuration
        wb[0] = 8'hFF;
        write_txn(8'h01, 1);
        check("R6 cfg stored", cfg_o, 5'h1F);
        read_txn(1, 1'b0, 8'h00);
        check("R6 cfg read upper zero", rb[0], 8'h1F);
        check("R11 cfg strobe", got_strobes, 1);
        // R13 shutdown bit set, bus still works
        read_txn(2, 1'b1, 8'h03);
        check("R13 read in shutdown", rb[0], 8'h61);
        wb[0] = 8'h0A;
        write_txn(8'h01, 1);
        check("R13 write in shutdown", cfg_o, 5'h0A);
        read_txn(2, 1'b1, 8'h03);

        // R4 invalid pointer: no ack, pointer stays 11
        write_txn(8'h06, 0);
        check("R4 bad pointer nack", ak[1], 0);
        read_txn(2, 1'b0, 8'h00);
        check("R4 pointer unchanged", rb[0], 8'h61);

        // R8 temperature is read-only
        temp = 9'h032;
        wb[0] = 8'h55;
        write_txn(8'h00, 1);
        check("R8 pointer ack", ak[1], 1);
        check("R8 data nack", ak[2], 0);
        read_txn(2, 1'b0, 8'h00);
        check("R8 temp unchanged", rb[0], hi(9'h032));
        check("R8 hyst untouched", thyst_o, 9'h096);

        // R7 partial write then three-byte write
        wb[0] = 8'h11;
        write_txn(8'h02, 1);
        check("R7 partial no change", thyst_o, 9'h096);
        wb[0] = 8'h22; wb[1] = 8'h00; wb[2] = 8'h33;
        write_txn(8'h02, 3);
        check("R7 third byte nack", ak[4], 0);
        check("R7 two-byte commit", thyst_o, 9'h044);

        // R1 abort by repeated START after one data byte
        bus_start; put_byte(aw(1'b0), a); put_byte(8'h03, a); put_byte(8'h7E, a);
        bus_start; put_byte(aw(1'b1), a);
        get_byte(1'b1, rb[0]); get_byte(1'b0, rb[1]); bus_stop;
        check("R1 abort keeps set", tset_o, 9'h0C3);
        check("R1 read after abort", rb[0], 8'h61);
        // R1 START in the middle of an address byte
        bus_start; put_bit(1); put_bit(0); put_bit(1);
        bus_start; put_byte(aw(1'b1), a); get_byte(1'b0, rb[0]); bus_stop;
        check("R1 restart mid address", a, 1);
        check("R1 restart data", rb[0], 8'h61);

        // R10 host NACK ends the read
        begin
            int s0;
            s0 = strobes;
            bus_start; put_byte(aw(1'b1), a); get_byte(1'b0, rb[0]); get_byte(1'b0, rb[1]); bus_stop;
            check("R10 no data after nack", rb[1], 8'hFF);
            check("R10 one strobe", strobes - s0, 1);
        end

        // R5 R11 long read alternates msb/lsb
        read_txn(4, 1'b0, 8'h00);
        check("R5 byte0", rb[0], 8'h61);
        check("R5 byte1", rb[1], 8'h80);
        check("R5 byte2", rb[2], 8'h61);
        check("R5 byte3", rb[3], 8'h80);
        check("R11 four strobes", got_strobes, 4);

        summary;
    end
endmodule